// File: doc/BRIEF.md
# Receiver Mute and Wake-up Control

This block sits beside an asynchronous serial receiver used on a shared multi-drop line. Each message on such a line starts with a header frame that carries the address of the intended node. A node that finds, after checking that header in software, that the message is not meant for it sets a mute request. From then on the block keeps the receiver quiet: completed frames, framing or noise errors and idle detections no longer raise any receive status flag.

The receiver returns to normal listening on one of two wake events, chosen by a mode input. In address-mark mode, a completed frame whose top data bit is set ends the mute. The top bit is bit 8 for 9-bit words and bit 7 for 8-bit words. That waking frame is delivered as a normal received word. In idle-line mode, the receiver's report of a full frame time of ones ends the mute, and the next header can then be received.

The controller is a two-state machine. In state LISTEN, every flag event passes through. In state MUTED, events are blocked. The transitions are:
- MUTE_REQ: LISTEN → MUTED, on the mute request.
- WAKE_ADDR: MUTED → LISTEN, on an address-marked frame in address-mark mode.
- WAKE_IDLE: MUTED → LISTEN, on an idle line in idle-line mode.
- HOLD: any other cycle stays in the current state.

A mute request in the same cycle as a wake event takes priority, so the machine stays in MUTED.

Top module: `rx_mute_wake`

## Requirements
- R1: After reset, `muted` is 0 (state LISTEN).
- R2: A cycle with `mute_req`=1 makes `muted` read 1 after the next rising clock edge, from either state.
- R3: While muted, a completed frame that does not wake the receiver raises neither `full_set` nor `err_set`.
- R4: While muted, `idle_set` stays 0 for any `idle_seen` pulse, including the one that wakes the receiver.
- R5: With `wake_sel`=1 (address-mark mode), a muted receiver seeing `frame_done`=1 with the top data bit set reads `muted`=0 after the next edge. The top data bit is `rx_word[8]` when `word9`=1 and `rx_word[7]` when `word9`=0.
- R6: The waking frame of R5 raises `full_set` in its own cycle, and `err_set` when `err_in`=1.
- R7: With `wake_sel`=0 (idle-line mode), a muted receiver seeing `idle_seen`=1 reads `muted`=0 after the next edge.
- R8: Each mode ignores the other mode's wake event. In idle-line mode an address-marked frame keeps the receiver muted. In address-mark mode an idle line keeps it muted.
- R9: In LISTEN, the outputs follow the inputs combinationally in the same cycle: `full_set`=`frame_done`, `err_set`=`frame_done`&`err_in`, `idle_set`=`idle_seen`.
- R10: A `mute_req` in the same cycle as a wake event leaves `muted`=1. In address-mark mode, the waking frame is still delivered as in R6.
- R11: With `word9`=0, `rx_word[8]` has no influence on the wake decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mute_req | input | 1 | Software request to mute (one-cycle pulse) |
| wake_sel | input | 1 | Wake method: 1 address mark, 0 idle line |
| word9 | input | 1 | Word length: 1 for 9 bits, 0 for 8 bits |
| frame_done | input | 1 | Pulse: a complete frame is in `rx_word` |
| rx_word | input | 9 | Received data word |
| err_in | input | 1 | The completed frame carries an error |
| idle_seen | input | 1 | Pulse: a full frame time of ones was seen |
| muted | output | 1 | Mute state; reads back as the software mute bit |
| full_set | output | 1 | Gated receive-full flag update |
| err_set | output | 1 | Gated error flag update |
| idle_set | output | 1 | Gated idle flag update |

## Verification
The bench sweeps every combination of starting state, wake mode, word length, the two candidate top bits, error, idle pulse, frame pulse and mute request. It compares the gated flags and the next mute state against an arithmetic model.

The sweep over bits 7 and 8 under both word lengths tells whether the top-bit selection follows the word length. The crossing of mode against event type tells apart the two wake methods. The cases where a mute request coincides with a wake event distinguish request priority from wake priority.

// File: rtl/rx_mute_pkg.sv
package rx_mute_pkg;
    typedef enum logic {
        ST_LISTEN = 1'b0,
        ST_MUTED  = 1'b1
    } mute_state_t;

    typedef enum logic {
        WAKE_IDLE = 1'b0,
        WAKE_ADDR = 1'b1
    } wake_mode_t;
endpackage

// File: rtl/rx_mute_msb.sv
module rx_mute_msb #(
    parameter int WORD_W = 9
) (
    input  logic [1:0] top_bits,
    input  logic       long_word,
    output logic       msb
);
    generate
        if (WORD_W >= 2) begin : g_sel
            // top_bits[1] is the long-word top bit, top_bits[0] the short one
            assign msb = long_word ? top_bits[1] : top_bits[0];
        end else begin : g_one
            assign msb = top_bits[0];
        end
    endgenerate
endmodule

// File: rtl/rx_mute_fsm.sv
module rx_mute_fsm
    import rx_mute_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mute_req,
    input  logic wake_addr,
    input  logic wake_idle,
    output logic muted
);
    mute_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LISTEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LISTEN: if (mute_req) state_d = ST_MUTED;
            ST_MUTED: begin
                if (mute_req)                    state_d = ST_MUTED;
                else if (wake_addr || wake_idle) state_d = ST_LISTEN;
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_LISTEN: muted = 1'b0;
            ST_MUTED:  muted = 1'b1;
            default:   muted = 1'b0;
        endcase
    end

    // R2
    mute_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |=> muted);
    // R5
    addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && wake_addr && !mute_req) |=> !muted);
    // R7
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && wake_idle && !mute_req) |=> !muted);
endmodule

// File: rtl/rx_mute_gate.sv
module rx_mute_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic muted,
    input  logic frame_done,
    input  logic err_in,
    input  logic idle_seen,
    input  logic wake_addr,
    output logic full_set,
    output logic err_set,
    output logic idle_set
);
    logic pass_frame;

    assign pass_frame = !muted || wake_addr;
    assign full_set   = frame_done && pass_frame;
    assign err_set    = frame_done && err_in && pass_frame;
    assign idle_set   = idle_seen && !muted;

    // R3
    muted_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && !wake_addr) |-> !(full_set || err_set));
    // R4
    muted_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        muted |-> !idle_set);
    // R6
    wake_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (muted && wake_addr && frame_done) |-> full_set);
endmodule

// File: rtl/rx_mute_wake.sv
module rx_mute_wake
    import rx_mute_pkg::*;
#(
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_req,
    input  logic              wake_sel,
    input  logic              word9,
    input  logic              frame_done,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              err_in,
    input  logic              idle_seen,
    output logic              muted,
    output logic              full_set,
    output logic              err_set,
    output logic              idle_set
);
    localparam int TOP_LONG  = WORD_W - 1;
    localparam int TOP_SHORT = WORD_W - 2;

    wake_mode_t mode;
    logic       msb;
    logic       wake_addr;
    logic       wake_idle;
    logic [1:0] top_bits;

    assign mode     = wake_mode_t'(wake_sel);
    assign top_bits = {rx_word[TOP_LONG], rx_word[TOP_SHORT]};

    wire unused_low = &{1'b0, rx_word[TOP_SHORT-1:0], 1'b0};

    rx_mute_msb #(.WORD_W(WORD_W)) u_msb (
        .top_bits  (top_bits),
        .long_word (word9),
        .msb       (msb)
    );

    assign wake_addr = (mode == WAKE_ADDR) && frame_done && msb;
    assign wake_idle = (mode == WAKE_IDLE) && idle_seen;

    rx_mute_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mute_req  (mute_req),
        .wake_addr (wake_addr),
        .wake_idle (wake_idle),
        .muted     (muted)
    );

    rx_mute_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .muted      (muted),
        .frame_done (frame_done),
        .err_in     (err_in),
        .idle_seen  (idle_seen),
        .wake_addr  (wake_addr),
        .full_set   (full_set),
        .err_set    (err_set),
        .idle_set   (idle_set)
    );
endmodule

// File: tb/rx_mute_wake_bench.sv
module rx_mute_wake_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mute_req = 1'b0, wake_sel = 1'b0, word9 = 1'b0;
    logic       frame_done = 1'b0, err_in = 1'b0, idle_seen = 1'b0;
    logic [8:0] rx_word = '0;
    logic       muted, full_set, err_set, idle_set;
    int         n_vec = 0, n_bad = 0;
    bit         finished = 0;

    always #2 clk = ~clk;

    rx_mute_wake u_rx_mute_wake (
        .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .wake_sel(wake_sel),
        .word9(word9), .frame_done(frame_done), .rx_word(rx_word),
        .err_in(err_in), .idle_seen(idle_seen), .muted(muted),
        .full_set(full_set), .err_set(err_set), .idle_set(idle_set)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        mute_req = 0; frame_done = 0; err_in = 0; idle_seen = 0; rx_word = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mute", muted, 1'b0);
        for (int v = 0; v < 512; v++) begin
            logic sm, ws, w9, b8, b7, er, id, fd, mr, msb, m, gate, wake, nm;
            sm = v[0]; ws = v[1]; w9 = v[2]; b8 = v[3]; b7 = v[4];
            er = v[5]; id = v[6]; fd = v[7]; mr = v[8];
            // bring to start state
            @(negedge clk);
            rst_n = 1'b0;
            clear_inputs();
            @(negedge clk);
            rst_n = 1'b1;
            check("R1 reset mute", muted, 1'b0);
            wake_sel = ws;
            word9 = w9;
            if (sm) begin
                mute_req = 1'b1;
                @(negedge clk);
                mute_req = 1'b0;
                check("R2 mute taken", muted, 1'b1);
            end
            // apply vector
            @(negedge clk);
            mute_req = mr; frame_done = fd; err_in = er; idle_seen = id;
            rx_word = {b8, b7, 7'(v * 37)};
            #1;
            m    = sm;
            msb  = w9 ? b8 : b7;
            gate = !m || (ws && fd && msb);
            wake = m && ((ws && fd && msb) || (!ws && id));
            nm   = mr ? 1'b1 : (wake ? 1'b0 : m);
            if (!m) begin
                check("R9 full pass", full_set, fd);
                check("R9 err pass", err_set, fd & er);
                check("R9 idle pass", idle_set, id);
            end else if (ws && fd && msb) begin
                check("R6 wake frame full", full_set, 1'b1);
                check("R6 wake frame err", err_set, er);
                check("R4 idle blocked", idle_set, 1'b0);
            end else begin
                check("R3 full blocked", full_set, fd & gate);
                check("R3 err blocked", err_set, fd & er & gate);
                check("R4 idle blocked", idle_set, 1'b0);
            end
            @(negedge clk);
            if (mr)
                check(wake ? "R10 request beats wake" : "R2 mute taken", muted, nm);
            else if (m && ws && fd && msb)
                check("R5 address wake", muted, nm);
            else if (m && !ws && id)
                check("R7 idle wake", muted, nm);
            else if (m && !w9 && b8 && fd && ws)
                check("R11 bit 8 ignored", muted, nm);
            else if (m)
                check("R8 other mode ignored", muted, nm);
            else
                check("R9 stays listening", muted, nm);
            clear_inputs();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule